// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Silence Flag

This block takes a three-wire stereo audio stream made of a bit clock, a word-select clock and a serial data line. From it, the block recovers one 16-bit two's-complement sample per channel in every word period. It runs entirely on the master clock. The bit clock, word select and data are oversampled through a shared synchronizer, so all three stay aligned with each other. No absolute clock frequency is assumed. The recovered left and right words are presented together on parallel outputs, with a single-cycle strobe.

Two monitors sit beside the datapath. The first counts frames in which both channels carry exactly zero, and raises a silence flag after a long unbroken run of them. The second measures the master-clock cycles in each word-select period and compares the count with the multiple chosen by a ratio select input. When the two differ, it reports a mismatch.

Top module: `ser_audio_rx`

## Requirements
- R1: While `rst_ni` is low, `left_o`, `right_o`, `valid_o`, `zero_o` and `ratio_err_o` are all 0, and the cycle after reset is removed they are still 0.
- R2: Serial data is sampled on rising edges of `sclk_i`, most significant bit first. A slot with `ws_i` high carries the left word and a slot with `ws_i` low carries the right word.
- R3: The first rising bit-clock edge after `ws_i` changes level carries bit 15 of the new word. Bits after the sixteenth in a slot have no effect on any output.
- R4: `left_o` and `right_o` change only in the cycle where `valid_o` is high. `valid_o` is a one-cycle pulse, issued once per frame after the sixteenth right-channel bit.
- R5: `zero_o` rises when a frame completes and it is the ZERO_FRAMES-th consecutive frame (default 8192) in which both words equal zero.
- R6: A nonzero word on either channel clears the silence count and drops `zero_o` as soon as that word completes, without waiting for the end of the frame.
- R7: The silence count saturates, so `zero_o` stays high through any number of further all-zero frames.
- R8: With `ratio_sel_i` = 0 the expected master-clock count per word-select period (rising edge to rising edge) is 256, and with `ratio_sel_i` = 1 it is 384. At each word-select rising edge, `ratio_err_o` is updated to show whether the period just ended differed from the expected count. The first period after reset is not judged.
- R9: The extreme codes 16'h8000, 16'h7FFF, 16'hFFFF and 16'h0001 pass through bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_sel_i | input | 1 | Master clock multiple: 0 = 256, 1 = 384 |
| sclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select: 1 = left slot, 0 = right slot |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 16 | Last complete left word |
| right_o | output | 16 | Last complete right word |
| valid_o | output | 1 | One-cycle strobe when a new left/right pair appears |
| zero_o | output | 1 | Sustained silence detected |
| ratio_err_o | output | 1 | Last word-select period did not match the selected multiple |

## Verification
The hardest situation to reach is the saturated silence state followed by a break in the silence that arrives mid-frame. A silent-frame counter in the thousands would take millions of master cycles to fill, so the bench overrides the count to sixteen frames and streams zero frames back to back until the flag rises. It then keeps streaming past the terminal count. After that it sends the left slot of a frame on its own, with a nonzero word, and samples the flag before the right slot begins. Reaching the ratio error also needs unbroken streams, so the frames are chained with no idle cycle between them.

// File: rtl/ser_audio_pkg.sv
`timescale 1ns/1ps
package ser_audio_pkg;
   typedef enum logic {
      RATIO_256 = 1'b0,
      RATIO_384 = 1'b1
   } ratio_sel_e;

   localparam int DEF_SAMPLE_W    = 16;
   localparam int DEF_SYNC_STAGES = 2;
   localparam int DEF_ZERO_FRAMES = 8192;
   localparam int DEF_RATIO_LO    = 256;
   localparam int DEF_RATIO_HI    = 384;

   // positions inside the synchronized input vector
   localparam int SYNC_BCLK = 0;
   localparam int SYNC_WS   = 1;
   localparam int SYNC_SD   = 2;
endpackage

// File: rtl/sar_edge_sync.sv
`timescale 1ns/1ps
module sar_edge_sync #(
   parameter int WIDTH  = 3,
   parameter int EDGE_W = 2,
   parameter int STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [WIDTH-1:0]  async_i,
   output logic [WIDTH-1:0]  level_o,
   output logic [EDGE_W-1:0] rise_o
);
   if (EDGE_W < 1 || EDGE_W > WIDTH) begin : g_bad_edge
      $error("sar_edge_sync: EDGE_W must lie in 1..WIDTH");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("sar_edge_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign level_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign level_o = stg_q[STAGES-1];
   end

   logic [EDGE_W-1:0] prev_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= level_o[EDGE_W-1:0];
   end

   assign rise_o = level_o[EDGE_W-1:0] & ~prev_q;
endmodule

// File: rtl/sar_deser.sv
`timescale 1ns/1ps
module sar_deser #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bit_rise_i,
   input  logic                ws_i,
   input  logic                sd_i,
   output logic                word_done_o,
   output logic                word_left_o,
   output logic [SAMPLE_W-1:0] word_data_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(SAMPLE_W);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("sar_deser: SAMPLE_W must be at least 2");
   end

   logic                ws_last_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [SAMPLE_W-2:0] shr_q;
   logic [SAMPLE_W-1:0] left_hold_q;
   logic                slot_start;
   logic                in_word;

   assign slot_start  = bit_rise_i && (ws_i != ws_last_q);
   assign in_word     = bit_rise_i && !slot_start && (cnt_q < FULL);
   assign word_done_o = in_word && (cnt_q == LAST_BIT);
   assign word_data_o = {shr_q, sd_i};
   assign word_left_o = ws_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ws_last_q   <= 1'b0;
         cnt_q       <= '0;
         shr_q       <= '0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (slot_start) begin
            ws_last_q <= ws_i;
            cnt_q     <= CNT_W'(1);
            shr_q     <= (SAMPLE_W-1)'(sd_i);
         end else if (in_word) begin
            cnt_q <= cnt_q + 1'b1;
            shr_q <= word_data_o[SAMPLE_W-2:0];
         end
         if (word_done_o) begin
            if (ws_i) begin
               left_hold_q <= word_data_o;
            end else begin
               left_o  <= left_hold_q;
               right_o <= word_data_o;
               valid_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sar_zero_det.sv
`timescale 1ns/1ps
module sar_zero_det #(
   parameter int SAMPLE_W    = 16,
   parameter int ZERO_FRAMES = 8192
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                done_i,
   input  logic                left_i,
   input  logic [SAMPLE_W-1:0] data_i,
   output logic                zero_o
);
   localparam int ZC_W = $clog2(ZERO_FRAMES + 1);
   localparam logic [ZC_W-1:0] TERM = ZC_W'(ZERO_FRAMES);

   if (ZERO_FRAMES < 1) begin : g_bad_frames
      $error("sar_zero_det: ZERO_FRAMES must be at least 1");
   end

   logic [ZC_W-1:0] cnt_q;
   logic            left_zero_q;
   logic            nonzero;
   logic [ZC_W-1:0] cnt_inc;

   assign nonzero = |data_i;
   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         left_zero_q <= 1'b0;
         zero_o      <= 1'b0;
      end else if (done_i) begin
         if (nonzero) begin
            cnt_q       <= '0;
            zero_o      <= 1'b0;
            left_zero_q <= 1'b0;
         end else if (left_i) begin
            left_zero_q <= 1'b1;
         end else begin
            left_zero_q <= 1'b0;
            if (!left_zero_q) begin
               cnt_q  <= '0;
               zero_o <= 1'b0;
            end else if (cnt_q != TERM) begin
               cnt_q  <= cnt_inc;
               zero_o <= (cnt_inc == TERM);
            end
         end
      end
   end
endmodule

// File: rtl/sar_ratio_chk.sv
`timescale 1ns/1ps
module sar_ratio_chk
   import ser_audio_pkg::*;
#(
   parameter int RATIO_LO = 256,
   parameter int RATIO_HI = 384
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ws_rise_i,
   input  ratio_sel_e sel_i,
   output logic       err_o
);
   localparam int RC_W = $clog2(RATIO_HI + 1) + 1;
   localparam logic [RC_W-1:0] CMAX = '1;

   if (RATIO_LO < 2 || RATIO_HI <= RATIO_LO) begin : g_bad_ratio
      $error("sar_ratio_chk: need 2 <= RATIO_LO < RATIO_HI");
   end

   logic [RC_W-1:0] cnt_q;
   logic [RC_W-1:0] expect_cnt;
   logic            armed_q;

   assign expect_cnt = (sel_i == RATIO_384) ? RC_W'(RATIO_HI) : RC_W'(RATIO_LO);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         err_o   <= 1'b0;
      end else if (ws_rise_i) begin
         cnt_q   <= RC_W'(1);
         armed_q <= 1'b1;
         if (armed_q) err_o <= (cnt_q != expect_cnt);
      end else if (cnt_q != CMAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ser_audio_rx.sv
`timescale 1ns/1ps
module ser_audio_rx
   import ser_audio_pkg::*;
#(
   parameter int SAMPLE_W    = DEF_SAMPLE_W,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int ZERO_FRAMES = DEF_ZERO_FRAMES,
   parameter int RATIO_LO    = DEF_RATIO_LO,
   parameter int RATIO_HI    = DEF_RATIO_HI
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                ratio_sel_i,
   input  logic                sclk_i,
   input  logic                ws_i,
   input  logic                sd_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o,
   output logic                zero_o,
   output logic                ratio_err_o
);
   localparam int IN_W   = 3;
   localparam int EDGE_W = 2;

   logic [IN_W-1:0]     raw_in;
   logic [IN_W-1:0]     sync_lvl;
   logic [EDGE_W-1:0]   sync_rise;
   logic                bit_rise;
   logic                ws_rise_w;
   logic                unused_bclk_lvl;
   logic                wd_done;
   logic                wd_left;
   logic [SAMPLE_W-1:0] wd_data;
   ratio_sel_e          sel_e;

   assign raw_in[SYNC_BCLK] = sclk_i;
   assign raw_in[SYNC_WS]   = ws_i;
   assign raw_in[SYNC_SD]   = sd_i;

   sar_edge_sync #(
      .WIDTH (IN_W),
      .EDGE_W(EDGE_W),
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(raw_in),
      .level_o(sync_lvl),
      .rise_o (sync_rise)
   );

   assign bit_rise        = sync_rise[SYNC_BCLK];
   assign ws_rise_w       = sync_rise[SYNC_WS];
   assign unused_bclk_lvl = sync_lvl[SYNC_BCLK];

   sar_deser #(
      .SAMPLE_W(SAMPLE_W)
   ) deser_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bit_rise_i (bit_rise),
      .ws_i       (sync_lvl[SYNC_WS]),
      .sd_i       (sync_lvl[SYNC_SD]),
      .word_done_o(wd_done),
      .word_left_o(wd_left),
      .word_data_o(wd_data),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o)
   );

   sar_zero_det #(
      .SAMPLE_W   (SAMPLE_W),
      .ZERO_FRAMES(ZERO_FRAMES)
   ) zero_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .done_i(wd_done),
      .left_i(wd_left),
      .data_i(wd_data),
      .zero_o(zero_o)
   );

   assign sel_e = ratio_sel_e'(ratio_sel_i);

   sar_ratio_chk #(
      .RATIO_LO(RATIO_LO),
      .RATIO_HI(RATIO_HI)
   ) ratio_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ws_rise_i(ws_rise_w),
      .sel_i    (sel_e),
      .err_o    (ratio_err_o)
   );
endmodule

// File: rtl/ser_audio_rx_chk.sv
`timescale 1ns/1ps
module ser_audio_rx_chk #(
   parameter int SAMPLE_W = 16
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                valid_o,
   input logic                zero_o,
   input logic                ratio_err_o,
   input logic                ws_rise_w,
   input logic                wd_done,
   input logic [SAMPLE_W-1:0] wd_data
);
   // R1: outputs are clear one cycle after reset is seen low
   p_reset_clear_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (left_o == '0 && right_o == '0 && !valid_o && !zero_o && !ratio_err_o));

   // R4: strobe lasts a single cycle
   p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   // R4: words hold between strobes
   p_words_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R5: the flag only rises with a delivered all-zero frame
   p_zero_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(zero_o) |-> (valid_o && left_o == '0 && right_o == '0));

   // R6: a delivered nonzero pair never coexists with the flag
   p_zero_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && (left_o != '0 || right_o != '0)) |-> !zero_o);

   // R7: once set, only a nonzero word drops the flag
   p_zero_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_o && !(wd_done && wd_data != '0)) |=> zero_o);

   // R8: the ratio verdict moves only on a word-select rising edge
   p_ratio_update_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ratio_err_o) |-> $past(ws_rise_w));
endmodule

bind ser_audio_rx ser_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .left_o     (left_o),
   .right_o    (right_o),
   .valid_o    (valid_o),
   .zero_o     (zero_o),
   .ratio_err_o(ratio_err_o),
   .ws_rise_w  (ws_rise_w),
   .wd_done    (wd_done),
   .wd_data    (wd_data)
);

// File: tb/ser_audio_rx_tb_top.sv
`timescale 1ns/1ps
module ser_audio_rx_tb_top;
   localparam int ZF   = 16;
   localparam int HALF = 2;   // master cycles per bit-clock phase
   localparam int SLOT_256 = 32;
   localparam int SLOT_384 = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        sclk = 1'b0;
   logic        ws = 1'b0;
   logic        sd = 1'b0;
   logic [15:0] left_o, right_o;
   logic        valid_o, zero_o, ratio_err_o;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   int run_len = 0;
   int max_run = 0;
   int cyc = 0;
   logic [15:0] cap_l = '0, cap_r = '0;

   always #2 clk = ~clk;

   ser_audio_rx #(.ZERO_FRAMES(ZF)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ratio_sel_i(sel),
      .sclk_i     (sclk),
      .ws_i       (ws),
      .sd_i       (sd),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o),
      .zero_o     (zero_o),
      .ratio_err_o(ratio_err_o)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(negedge clk) begin
      if (valid_o) begin
         vcount++;
         cap_l = left_o;
         cap_r = right_o;
         run_len++;
         if (run_len > max_run) max_run = run_len;
      end else begin
         run_len = 0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(logic w, logic d);
      sclk = 1'b0; ws = w; sd = d;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_slot(logic w, logic [15:0] word, int bits, logic pad);
      for (int i = 0; i < bits; i++) begin
         if (i < 16) send_bit(w, word[15-i]);
         else        send_bit(w, pad);
      end
   endtask

   task automatic send_frame(logic [15:0] l, logic [15:0] r, int bits, logic pad);
      send_slot(1'b1, l, bits, pad);
      send_slot(1'b0, r, bits, pad);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sclk = 1'b0; ws = 1'b0; sd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 left after reset", 32'(left_o), 32'h0);
      check("R1 right after reset", 32'(right_o), 32'h0);
      check("R1 flags after reset", {29'd0, valid_o, zero_o, ratio_err_o}, 32'h0);
   endtask

   task automatic t_basic_frame();
      int v0;
      v0 = vcount;
      send_frame(16'h1234, 16'hABCD, SLOT_256, 1'b0);
      check("R2 left word", 32'(cap_l), 32'h1234);
      check("R2 right word", 32'(cap_r), 32'hABCD);
      check("R4 one strobe per frame", 32'(vcount - v0), 32'd1);
      send_frame(16'h5A5A, 16'h00FF, SLOT_256, 1'b0);
      check("R2 second pair", {cap_l, cap_r}, 32'h5A5A00FF);
      check("R4 strobe width", 32'(max_run), 32'd1);
   endtask

   task automatic t_extremes();
      send_frame(16'h8000, 16'h7FFF, SLOT_256, 1'b0);
      check("R9 min/max codes", {cap_l, cap_r}, 32'h80007FFF);
      send_frame(16'hFFFF, 16'h0001, SLOT_256, 1'b0);
      check("R9 minus one / plus one", {cap_l, cap_r}, 32'hFFFF0001);
   endtask

   task automatic t_padding();
      // trailing ones beyond bit 16 must be discarded
      send_frame(16'h00F0, 16'h0F00, SLOT_256, 1'b1);
      check("R3 padding ignored", {cap_l, cap_r}, 32'h00F00F00);
      send_frame(16'hC003, 16'h3C00, SLOT_384, 1'b1);
      check("R3 long slot padding ignored", {cap_l, cap_r}, 32'hC0033C00);
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 outputs cleared in reset", {left_o, right_o}, 32'h0);
      check("R1 flags cleared in reset", {29'd0, valid_o, zero_o, ratio_err_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_silence();
      do_reset();
      for (int i = 0; i < ZF - 1; i++) send_frame(16'h0000, 16'h0000, SLOT_256, 1'b0);
      check("R5 flag low one frame short", 32'(zero_o), 32'd0);
      send_frame(16'h0000, 16'h0000, SLOT_256, 1'b0);
      check("R5 flag high at terminal count", 32'(zero_o), 32'd1);
      for (int i = 0; i < 6; i++) send_frame(16'h0000, 16'h0000, SLOT_256, 1'b1);
      check("R7 flag held past terminal count", 32'(zero_o), 32'd1);
      send_slot(1'b1, 16'h0040, SLOT_256, 1'b0);
      check("R6 left nonzero drops flag mid-frame", 32'(zero_o), 32'd0);
      send_slot(1'b0, 16'h0000, SLOT_256, 1'b0);
      for (int i = 0; i < ZF - 1; i++) send_frame(16'h0000, 16'h0000, SLOT_256, 1'b0);
      check("R6 count restarted after break", 32'(zero_o), 32'd0);
      send_frame(16'h0000, 16'h0000, SLOT_256, 1'b0);
      check("R5 flag high again", 32'(zero_o), 32'd1);
      send_frame(16'h0000, 16'h8000, SLOT_256, 1'b0);
      check("R6 right nonzero drops flag", 32'(zero_o), 32'd0);
   endtask

   task automatic t_ratio();
      do_reset();
      sel = 1'b0;
      repeat (3) send_frame(16'h1111, 16'h2222, SLOT_256, 1'b0);
      check("R8 256 frames with select low", 32'(ratio_err_o), 32'd0);
      sel = 1'b1;
      repeat (2) send_frame(16'h1111, 16'h2222, SLOT_256, 1'b0);
      check("R8 256 frames with select high", 32'(ratio_err_o), 32'd1);
      repeat (2) send_frame(16'h3333, 16'h4444, SLOT_384, 1'b0);
      check("R8 384 frames with select high", 32'(ratio_err_o), 32'd0);
      check("R2 pair in 384 framing", {cap_l, cap_r}, 32'h33334444);
      sel = 1'b0;
      repeat (2) send_frame(16'h3333, 16'h4444, SLOT_384, 1'b0);
      check("R8 384 frames with select low", 32'(ratio_err_o), 32'd1);
   endtask

   initial begin
      t_reset_state();
      t_basic_frame();
      t_extremes();
      t_padding();
      t_mid_reset();
      t_silence();
      t_ratio();
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule